// File: doc/BRIEF.md
# Eight-Channel Compare Timer

A shared event timer for a larger chip. A 64-bit main count advances once for every rising edge of a slow reference clock. That reference clock runs with no fixed phase relation to the fast system clock, so it is first synchronized into the system clock domain. Each detected edge becomes a one-cycle advance enable. The spacing of these enables is uneven, but their long-term rate matches the reference exactly.

Eight compare channels watch the one count. Each channel holds a 64-bit target and a 64-bit period. When the count steps onto the target, the channel sets a sticky event flag. The flag drives that channel's own interrupt line while the channel's interrupt mask bit is set. A channel works in one of two modes:
- One-shot: the channel fires once, then waits for software to rewrite its target.
- Repeating: after each hit, the channel adds its period to the target.

Software reaches every register through a simple synchronous word bus. The bus has an address, write data, a write strobe and registered read data.

Top module: `evt_timer_unit`

## Requirements
- R1: After reset, the count, the event flags and every interrupt output are zero, and reads of the count return zero.
- R2: While the run bit (word 0, bit 0) is 1, the count rises by exactly one per rising edge of `ref_clk`. Over any long interval, the count change stays within one of the number of reference edges.
- R3: While the run bit is 0, the count holds its value.
- R4: The count is read and written as two 32-bit words: word 1 is the low half and word 2 is the high half. A write takes effect even while the count runs. The count wraps from all ones to zero.
- R5: Read data is registered and is valid in the cycle after the address. Two reads of the low count word taken more than one reference period apart return strictly increasing values, unless the count wrapped between them.
- R6: Channel n owns words 16+4n (target low), 17+4n (target high), 18+4n (period low) and 19+4n (period high). Channel n's event flag is bit n of word 3. The flag is set within two cycles after the count steps onto the channel's armed target. Writing a target half arms the channel.
- R7: Output `irq[n]` is high exactly while event flag n and mask bit n (word 4) are both 1. A hit with the mask bit clear still sets the flag.
- R8: Writing word 3 clears each event flag whose data bit is 1 and leaves the other flags unchanged. Event flags stay set until cleared.
- R9: In one-shot mode, a channel disarms after its hit. It does not fire again, even if the count returns to the target, until a target half is rewritten.
- R10: When bit n of word 5 is 1, channel n repeats. On each hit its target grows by its period, the new target reads back from the target words, and the channel fires again there.
- R11: The eight channels act independently: each channel raises only its own flag and interrupt, at its own target.
- R12: Each rising edge of the reference clock yields exactly one single-cycle advance enable, never two in a row.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset; release is synchronized inside the block |
| ref_clk | input | 1 | Slow reference clock, asynchronous to clk |
| addr | input | 6 | Word address |
| wdata | input | 32 | Write data |
| we | input | 1 | Write strobe, one word per cycle |
| rdata | output | 32 | Read data, registered, valid the cycle after addr |
| irq | output | 8 | Per-channel interrupt outputs |

## Verification
The count is compared against an independent tally of reference-clock edges. This is done over several long random windows, and also across a run-bit toggle, which separates a lost or doubled advance from a missed hold. Each channel is then given a random target a few ticks ahead. The count is read back when its interrupt rises, which exposes off-by-one or cross-channel firing.

Directed patterns cover four further cases:
- A count rewound below a spent one-shot target, which shows whether the channel truly disarmed.
- A masked hit, which separates the flag from the interrupt line.
- A partial flag clear.
- A repeating channel whose reloaded target is read back.

A count preset just below all ones shows the carry between the two halves and the wrap to zero.

// File: rtl/etu_pkg.sv
package etu_pkg;

  // Word addresses of the shared registers
  localparam int unsigned ADR_RUN    = 0;
  localparam int unsigned ADR_CNT_LO = 1;
  localparam int unsigned ADR_CNT_HI = 2;
  localparam int unsigned ADR_FLAGS  = 3;
  localparam int unsigned ADR_MASK   = 4;
  localparam int unsigned ADR_REPEAT = 5;

  // Per-channel block: base + stride * channel
  localparam int unsigned ADR_CH_BASE   = 16;
  localparam int unsigned ADR_CH_STRIDE = 4;

  // Write strobes into one channel
  typedef struct packed {
    logic tgt_lo;
    logic tgt_hi;
    logic per_lo;
    logic per_hi;
  } chan_wr_t;

endpackage

// File: rtl/etu_rst_sync.sv
module etu_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] stage_q;
  logic [1:0] stage_d;

  always_comb begin
    stage_d = {stage_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= stage_d;
  end

  assign rst_sync_n = stage_q[1];

endmodule

// File: rtl/etu_ref_sync.sv
module etu_ref_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_clk,
  output logic tick_o
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;
  logic              last_q;
  logic              last_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], ref_clk};
    last_d = sync_q[STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      last_q <= last_d;
    end
  end

  assign tick_o = sync_q[STAGES-1] & ~last_q;

  // One edge gives one enable cycle
  assert_tick_single_R12: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |=> !tick_o);

endmodule

// File: rtl/etu_counter.sv
module etu_counter #(
  parameter int unsigned DW = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run_i,
  input  logic            tick_i,
  input  logic            wr_lo_i,
  input  logic            wr_hi_i,
  input  logic [DW-1:0]   wdata_i,
  output logic [2*DW-1:0] cnt_o,
  output logic            adv_o
);

  localparam int unsigned CW = 2 * DW;

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          adv_q;
  logic          adv_d;
  logic          step;

  always_comb begin
    step  = run_i & tick_i;
    cnt_d = cnt_q;
    if (wr_lo_i || wr_hi_i) begin
      if (wr_lo_i) cnt_d[DW-1:0]  = wdata_i;
      if (wr_hi_i) cnt_d[CW-1:DW] = wdata_i;
    end else if (step) begin
      cnt_d = cnt_q + CW'(1);
    end
    adv_d = step & ~wr_lo_i & ~wr_hi_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      adv_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      adv_q <= adv_d;
    end
  end

  assign cnt_o = cnt_q;
  assign adv_o = adv_q;

  assert_cnt_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_lo_i && !wr_hi_i) |=>
      ((cnt_q == $past(cnt_q)) || (cnt_q == $past(cnt_q) + CW'(1))));

  assert_cnt_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_i && !wr_lo_i && !wr_hi_i) |=> $stable(cnt_q));

endmodule

// File: rtl/etu_channel.sv
module etu_channel
  import etu_pkg::*;
#(
  parameter int unsigned DW = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [2*DW-1:0] cnt_i,
  input  logic            adv_i,
  input  chan_wr_t        wr_i,
  input  logic [DW-1:0]   wdata_i,
  input  logic            repeat_i,
  input  logic            mask_i,
  input  logic            clr_i,
  output logic [2*DW-1:0] tgt_o,
  output logic [2*DW-1:0] per_o,
  output logic            flag_o,
  output logic            irq_o
);

  localparam int unsigned CW = 2 * DW;

  logic [CW-1:0] tgt_q, tgt_d;
  logic [CW-1:0] per_q, per_d;
  logic          armed_q, armed_d;
  logic          flag_q, flag_d;
  logic          hit;
  logic          tgt_wr;

  always_comb begin
    tgt_wr = wr_i.tgt_lo | wr_i.tgt_hi;
    hit    = adv_i & armed_q & (cnt_i == tgt_q);

    tgt_d = tgt_q;
    if (tgt_wr) begin
      if (wr_i.tgt_lo) tgt_d[DW-1:0]  = wdata_i;
      if (wr_i.tgt_hi) tgt_d[CW-1:DW] = wdata_i;
    end else if (hit && repeat_i) begin
      tgt_d = tgt_q + per_q;
    end

    per_d = per_q;
    if (wr_i.per_lo) per_d[DW-1:0]  = wdata_i;
    if (wr_i.per_hi) per_d[CW-1:DW] = wdata_i;

    armed_d = armed_q;
    if (tgt_wr)                armed_d = 1'b1;
    else if (hit && !repeat_i) armed_d = 1'b0;

    flag_d = hit | (flag_q & ~clr_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tgt_q   <= '0;
      per_q   <= '0;
      armed_q <= 1'b0;
      flag_q  <= 1'b0;
    end else begin
      tgt_q   <= tgt_d;
      per_q   <= per_d;
      armed_q <= armed_d;
      flag_q  <= flag_d;
    end
  end

  assign tgt_o  = tgt_q;
  assign per_o  = per_q;
  assign flag_o = flag_q;
  assign irq_o  = flag_q & mask_i;

  assert_period_reload_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && repeat_i && !tgt_wr) |=> (tgt_q == $past(tgt_q) + $past(per_q)));

  assert_oneshot_disarm_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !repeat_i && !tgt_wr) |=> !armed_q);

  assert_flag_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !clr_i) |=> flag_q);

endmodule

// File: rtl/evt_timer_unit.sv
module evt_timer_unit
  import etu_pkg::*;
#(
  parameter int unsigned DW          = 32,
  parameter int unsigned AW          = 6,
  parameter int unsigned NCH         = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           ref_clk,
  input  logic [AW-1:0]  addr,
  input  logic [DW-1:0]  wdata,
  input  logic           we,
  output logic [DW-1:0]  rdata,
  output logic [NCH-1:0] irq
);

  localparam int unsigned CW = 2 * DW;

  logic           rst_s_n;
  logic           tick;
  logic [CW-1:0]  cnt;
  logic           adv;

  logic           run_q, run_d;
  logic [NCH-1:0] mask_q, mask_d;
  logic [NCH-1:0] rep_q, rep_d;
  logic [DW-1:0]  rd_q, rd_d;

  logic           wr_run, wr_mask, wr_rep, wr_flags, wr_cnt_lo, wr_cnt_hi;
  logic [NCH-1:0] clr;
  logic [NCH-1:0] flags;
  chan_wr_t       ch_wr [NCH];
  logic [CW-1:0]  tgt_w [NCH];
  logic [CW-1:0]  per_w [NCH];

  etu_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_s_n)
  );

  etu_ref_sync #(.STAGES(SYNC_STAGES)) u_ref (
    .clk     (clk),
    .rst_n   (rst_s_n),
    .ref_clk (ref_clk),
    .tick_o  (tick)
  );

  etu_counter #(.DW(DW)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_s_n),
    .run_i   (run_q),
    .tick_i  (tick),
    .wr_lo_i (wr_cnt_lo),
    .wr_hi_i (wr_cnt_hi),
    .wdata_i (wdata),
    .cnt_o   (cnt),
    .adv_o   (adv)
  );

  // Write decode for shared words
  always_comb begin
    wr_run    = we && (addr == AW'(ADR_RUN));
    wr_cnt_lo = we && (addr == AW'(ADR_CNT_LO));
    wr_cnt_hi = we && (addr == AW'(ADR_CNT_HI));
    wr_flags  = we && (addr == AW'(ADR_FLAGS));
    wr_mask   = we && (addr == AW'(ADR_MASK));
    wr_rep    = we && (addr == AW'(ADR_REPEAT));
    clr       = wr_flags ? wdata[NCH-1:0] : '0;
  end

  // Control register next state
  always_comb begin
    run_d  = wr_run  ? wdata[0]        : run_q;
    mask_d = wr_mask ? wdata[NCH-1:0]  : mask_q;
    rep_d  = wr_rep  ? wdata[NCH-1:0]  : rep_q;
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      run_q  <= 1'b0;
      mask_q <= '0;
      rep_q  <= '0;
    end else begin
      run_q  <= run_d;
      mask_q <= mask_d;
      rep_q  <= rep_d;
    end
  end

  // Channel instances
  for (genvar g = 0; g < NCH; g++) begin : g_ch
    localparam logic [AW-1:0] BASE = AW'(ADR_CH_BASE + ADR_CH_STRIDE * g);

    always_comb begin
      ch_wr[g].tgt_lo = we && (addr == BASE);
      ch_wr[g].tgt_hi = we && (addr == BASE + AW'(1));
      ch_wr[g].per_lo = we && (addr == BASE + AW'(2));
      ch_wr[g].per_hi = we && (addr == BASE + AW'(3));
    end

    etu_channel #(.DW(DW)) u_chan (
      .clk      (clk),
      .rst_n    (rst_s_n),
      .cnt_i    (cnt),
      .adv_i    (adv),
      .wr_i     (ch_wr[g]),
      .wdata_i  (wdata),
      .repeat_i (rep_q[g]),
      .mask_i   (mask_q[g]),
      .clr_i    (clr[g]),
      .tgt_o    (tgt_w[g]),
      .per_o    (per_w[g]),
      .flag_o   (flags[g]),
      .irq_o    (irq[g])
    );
  end

  // Read mux, registered
  always_comb begin
    rd_d = '0;
    if (addr == AW'(ADR_RUN))    rd_d = DW'(run_q);
    if (addr == AW'(ADR_CNT_LO)) rd_d = cnt[DW-1:0];
    if (addr == AW'(ADR_CNT_HI)) rd_d = cnt[CW-1:DW];
    if (addr == AW'(ADR_FLAGS))  rd_d = DW'(flags);
    if (addr == AW'(ADR_MASK))   rd_d = DW'(mask_q);
    if (addr == AW'(ADR_REPEAT)) rd_d = DW'(rep_q);
    for (int i = 0; i < NCH; i++) begin
      if (addr == AW'(ADR_CH_BASE + ADR_CH_STRIDE * i))     rd_d = tgt_w[i][DW-1:0];
      if (addr == AW'(ADR_CH_BASE + ADR_CH_STRIDE * i + 1)) rd_d = tgt_w[i][CW-1:DW];
      if (addr == AW'(ADR_CH_BASE + ADR_CH_STRIDE * i + 2)) rd_d = per_w[i][DW-1:0];
      if (addr == AW'(ADR_CH_BASE + ADR_CH_STRIDE * i + 3)) rd_d = per_w[i][CW-1:DW];
    end
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) rd_q <= '0;
    else          rd_q <= rd_d;
  end

  assign rdata = rd_q;

  // A masked channel never drives its line
  assert_irq_masked_R7: assert property (@(posedge clk) disable iff (!rst_s_n)
    (!mask_q[0] && !$past(wr_mask)) |-> !irq[0]);

endmodule

// File: tb/test_evt_timer_unit.sv
`timescale 1ns/1ps
module test_evt_timer_unit;

  localparam int A_RUN = 0, A_CLO = 1, A_CHI = 2, A_FLG = 3, A_MSK = 4, A_REP = 5;

  logic        clk = 1'b0;
  logic        ref_clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic        we = 1'b0;
  logic [31:0] rdata;
  logic [7:0]  irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  int unsigned edges = 0;

  evt_timer_unit i_evt_timer_unit (
    .clk(clk), .rst_n(rst_n), .ref_clk(ref_clk), .addr(addr),
    .wdata(wdata), .we(we), .rdata(rdata), .irq(irq)
  );

  always #5 clk = ~clk;
  always #34.92 ref_clk = ~ref_clk;
  always @(posedge ref_clk) edges++;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    addr = 6'(a); wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    addr = 6'(a);
    @(negedge clk);
    d = rdata;
  endtask

  task automatic now64(output logic [63:0] v);
    logic [31:0] h, l;
    rd(A_CHI, h); rd(A_CLO, l);
    v = {h, l};
  endtask

  task automatic arm(input int ch, input logic [63:0] t);
    wr(16 + 4*ch, t[31:0]);
    wr(17 + 4*ch, t[63:32]);
  endtask

  task automatic wait_irq(input int ch, input int lim, output bit got);
    got = 0;
    for (int k = 0; k < lim; k++) begin
      if (irq[ch]) begin got = 1; break; end
      @(negedge clk);
    end
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] d, d2, prev;
    logic [63:0] t, c;
    logic [63:0] tgt [8];
    int unsigned e0, e1;
    bit got;
    void'($urandom(32'd2024));

    idle(4); rst_n = 1'b1; idle(4);

    // R1 reset state
    chk(irq == 8'h00, "R1 irq", irq, 0);
    rd(A_CLO, d); chk(d == 0, "R1 cnt lo", d, 0);
    rd(A_CHI, d); chk(d == 0, "R1 cnt hi", d, 0);
    rd(A_FLG, d); chk(d == 0, "R1 flags", d, 0);

    // R3 stopped count holds
    idle(50);
    rd(A_CLO, d); chk(d == 0, "R3 hold while stopped", d, 0);

    // R2 count versus reference edges
    wr(A_RUN, 1);
    for (int w = 0; w < 3; w++) begin
      rd(A_CLO, d); e0 = edges;
      idle(500 + $urandom_range(1500));
      rd(A_CLO, d2); e1 = edges;
      chk(((d2 - d) + 1 >= (e1 - e0)) && ((d2 - d) <= (e1 - e0) + 1),
          "R2 count vs edges", d2 - d, e1 - e0);
    end

    // R5 strictly increasing reads
    rd(A_CLO, prev);
    for (int k = 0; k < 20; k++) begin
      idle(8 + $urandom_range(20));
      rd(A_CLO, d);
      chk(d > prev, "R5 increasing read", d, prev + 1);
      prev = d;
    end

    // R3 run bit off mid-stream
    wr(A_RUN, 0);
    rd(A_CLO, d); idle(80); rd(A_CLO, d2);
    chk(d2 == d, "R3 hold after stop", d2, d);
    wr(A_RUN, 1);

    // R6 R11 each channel one-shot with random distance
    wr(A_MSK, 32'hFF);
    for (int ch = 0; ch < 8; ch++) begin
      now64(c);
      t = c + 64'(6 + $urandom_range(24));
      tgt[ch] = t;
      arm(ch, t);
      wait_irq(ch, 600, got);
      chk(got, "R6 channel fired", 64'(ch), 64'(ch));
      chk(irq == 8'(1 << ch), "R11 only own irq", irq, 64'(1 << ch));
      rd(A_CLO, d);
      chk(d == t[31:0] || d == t[31:0] + 1, "R6 hit time", d, t[31:0]);
      wr(A_FLG, 32'(1 << ch));
      rd(A_FLG, d);
      chk(d == 0, "R8 flag cleared", d, 0);
    end

    // R9 rewind below spent one-shot target
    wr(A_RUN, 0);
    wr(A_CLO, tgt[2][31:0] - 32'd5);
    wr(A_CHI, tgt[2][63:32]);
    rd(A_CLO, d); chk(d == tgt[2][31:0] - 32'd5, "R4 count write lo", d, tgt[2][31:0] - 5);
    wr(A_RUN, 1);
    idle(160);
    rd(A_CLO, d); chk(d > tgt[2][31:0], "R9 count passed target", d, tgt[2][31:0]);
    rd(A_FLG, d); chk(d[2] == 1'b0, "R9 no refire", d, 0);
    chk(irq[2] == 1'b0, "R9 irq quiet", irq, 0);

    // R7 masked hit
    wr(A_MSK, 0);
    now64(c); arm(5, c + 64'd8);
    idle(140);
    rd(A_FLG, d); chk(d == 32'h20, "R7 masked flag set", d, 32'h20);
    chk(irq == 8'h00, "R7 masked irq low", irq, 0);
    wr(A_MSK, 32'hFF);
    chk(irq == 8'h20, "R7 irq after unmask", irq, 8'h20);
    wr(A_FLG, 32'h20);

    // R8 partial clear
    now64(c); arm(0, c + 64'd6); arm(1, c + 64'd9);
    idle(140);
    rd(A_FLG, d); chk(d == 32'h3, "R8 two flags", d, 3);
    wr(A_FLG, 0);
    rd(A_FLG, d); chk(d == 32'h3, "R8 zero write keeps", d, 3);
    wr(A_FLG, 32'h2);
    rd(A_FLG, d); chk(d == 32'h1, "R8 partial clear", d, 1);
    wr(A_FLG, 32'h1);
    chk(irq == 8'h00, "R8 irq cleared", irq, 0);

    // R10 repeating channel
    wr(A_REP, 32'h08);
    wr(18 + 12, 32'd12); wr(19 + 12, 0);
    now64(c); t = c + 64'd10; arm(3, t);
    wait_irq(3, 600, got);
    chk(got, "R10 first hit", 0, 1);
    rd(16 + 12, d); chk(d == t[31:0] + 32'd12, "R10 target reloaded", d, t[31:0] + 12);
    wr(A_FLG, 32'h08);
    wait_irq(3, 900, got);
    chk(got, "R10 second hit", 0, 1);
    rd(A_CLO, d);
    chk(d == t[31:0] + 12 || d == t[31:0] + 13, "R10 second hit time", d, t[31:0] + 12);
    wr(A_REP, 0); wr(A_FLG, 32'hFF);

    // R4 wrap through all ones
    wr(A_RUN, 0);
    wr(A_CHI, 32'hFFFF_FFFF); wr(A_CLO, 32'hFFFF_FFF8);
    rd(A_CHI, d); chk(d == 32'hFFFF_FFFF, "R4 count write hi", d, 32'hFFFF_FFFF);
    wr(A_RUN, 1);
    idle(200);
    rd(A_CHI, d); chk(d == 0, "R4 wrap hi", d, 0);
    rd(A_CLO, d); chk(d > 0 && d < 64, "R4 wrap lo", d, 20);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule